// File: doc/BRIEF.md
# Prioritized Exception Masking Arbiter

This block decides which exception source, if any, the processor core should enter next. Every source keeps its own lifecycle state (idle, waiting, in service, or in service with a fresh request waiting behind it). Each cycle the arbiter compares the waiting sources against the current execution priority. That priority is the most urgent level among the handlers in service, pushed further up by three masks: a single-bit global mask, a single-bit fault mask and a numeric threshold.

Source 0 is the non-maskable source and source 1 is the hard-fault source. Both have fixed levels above every configurable source and no enable bit. Sources 2 and up each have an enable and an 8-bit priority. Only the upper PRIO_BITS bits of that priority are kept, and a smaller number means more urgent. A grouping field splits the kept bits into a preemption part and a sub-priority part. The core accepts the presented winner with an acknowledge strobe and signals the end of a handler with a return strobe that carries the source number.

Top module: `exc_prio_arbiter`

## Requirements
- R1: After reset, take_req is 0, exec_prio is 511 (thread level, nothing in service) and fault_mask is 0.
- R2: A source that is requested while its handler is in service keeps its in-service state and is also marked waiting. Its return then leaves it waiting, and it is presented again with no new request.
- R3: A waiting configurable source i is presented only while src_en[i-2] is 1. Its request is still recorded while it is disabled. Sources 0 and 1 have no enable.
- R4: Levels are encoded as follows: 0 for source 0, 1 for source 1, and 2 + preemption part for a configurable source. exec_prio is the minimum of the levels of in-service sources and the active mask levels, or 511 when there is none. It is registered, so it reflects the state one cycle earlier.
- R5: A waiting source is presented only when its level is strictly lower than the current execution priority.
- R6: While global_mask is 1, the execution priority is at most 2, so only sources 0 and 1 can be presented.
- R7: A pulse on fault_mask_wr loads fault_mask_val. While fault_mask is 1 the execution priority is at most 1, so source 1 is blocked. A return strobe for any source other than 0 clears fault_mask, and this takes precedence over a write in the same cycle.
- R8: If thresh has any implemented bit set, its masked preemption part T raises the execution priority to at most 2+T. Sources whose preemption part is T or larger are then blocked.
- R9: The priority bits below the top PRIO_BITS bits are ignored, and the threshold bits below them are ignored too.
- R10: For a grouping value g, bits 7..g+1 of the kept priority form the preemption part and bits g..0 form the sub-priority. Among the eligible sources, the winner has the lowest level, then the lowest sub-priority, then the lowest source number.
- R11: sw_pend_set marks a source waiting and sw_pend_clr removes the mark. A clear wins over a set in the same cycle, and a hardware request in that cycle wins over both.
- R12: An ack while take_req is 1 moves the source on take_id from waiting to in service, and take_req is 0 in the following cycle. An ack while take_req is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Hardware request pulse for each source |
| sw_pend_set | input | NUM_SRC | Software set-waiting strobe for each source |
| sw_pend_clr | input | NUM_SRC | Software clear-waiting strobe for each source |
| src_en | input | NUM_SRC-2 | Enable for each configurable source (bit i-2 for source i) |
| src_prio | input | (NUM_SRC-2)*8 | 8-bit priority for each configurable source, byte i-2 for source i |
| prio_group | input | 3 | Grouping value g that splits preemption and sub-priority |
| global_mask | input | 1 | Blocks every source except 0 and 1 |
| fault_mask_wr | input | 1 | Write strobe for the fault mask |
| fault_mask_val | input | 1 | Value loaded into the fault mask |
| thresh | input | 8 | Threshold mask value; zero in the implemented bits disables it |
| ack | input | 1 | Core accepts the presented source |
| ret | input | 1 | Core returns from a handler |
| ret_id | input | ID_W | Source whose handler returns |
| take_req | output | 1 | A source should preempt now |
| take_id | output | ID_W | Number of the presented source |
| exec_prio | output | 9 | Current execution priority level |
| fault_mask | output | 1 | Current fault mask bit |

## Verification
The hardest situation to reach is a nested sequence in which a source is requested again while its own handler runs and another source of equal preemption level is waiting. On the return, the arbiter must re-present the source in the in-service-and-waiting state, and the tie must be broken by source number. The bench reaches this with a scripted chain of acknowledges and returns. It also sweeps every grouping value against every pair of implemented priorities, with junk bits added in the unimplemented positions, and sweeps the threshold against every priority. This covers the tie rules and the mask comparisons.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int PRIO_W      = 8;
  localparam int LVL_W       = 9;
  localparam int FIXED_SRCS  = 2;
  localparam logic [LVL_W-1:0] LVL_IDLE   = '1;
  localparam logic [LVL_W-1:0] LVL_NMASK  = 9'd0;
  localparam logic [LVL_W-1:0] LVL_FAULT  = 9'd1;
  localparam logic [LVL_W-1:0] LVL_CFG0   = 9'd2;

  // keep only the upper 'bits' bits of a priority byte
  function automatic logic [PRIO_W-1:0] impl_mask(input int bits);
    logic [15:0] t;
    t = 16'h00FF << (PRIO_W - bits);
    return t[PRIO_W-1:0];
  endfunction

  // bits 7..g+1 form the preemption part
  function automatic logic [PRIO_W-1:0] pre_mask(input logic [2:0] g);
    logic [15:0] t;
    t = 16'h00FF << (int'(g) + 1);
    return t[PRIO_W-1:0];
  endfunction
endpackage

// File: rtl/exc_src_state.sv
module exc_src_state (
  input  logic clk,
  input  logic rst,
  input  logic hw_req,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic ack_hit,
  input  logic ret_hit,
  output logic pend,
  output logic act
);
  // {act,pend}: 00 idle, 01 waiting, 10 in service, 11 in service + waiting
  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      pend <= 1'b0;
    end else begin
      act  <= (act & ~ret_hit) | ack_hit;
      pend <= ((((pend & ~ack_hit) | sw_set) & ~sw_clr)) | hw_req;
    end
  end
endmodule

// File: rtl/exc_level_calc.sv
module exc_level_calc
  import exc_arb_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int PRIO_BITS = 3
) (
  input  logic [(NUM_SRC-FIXED_SRCS)*PRIO_W-1:0] prio_cfg,
  input  logic [2:0]                             grp,
  output logic [NUM_SRC*LVL_W-1:0]               lvl_flat,
  output logic [NUM_SRC*PRIO_W-1:0]              sub_flat
);
  localparam logic [PRIO_W-1:0] IMPL = impl_mask(PRIO_BITS);

  logic [PRIO_W-1:0] pm;
  assign pm = pre_mask(grp);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i < FIXED_SRCS) begin : g_fixed
      assign lvl_flat[i*LVL_W +: LVL_W]   = LVL_W'(i);
      assign sub_flat[i*PRIO_W +: PRIO_W] = '0;
    end else begin : g_cfg
      logic [PRIO_W-1:0] kept;
      assign kept = prio_cfg[(i-FIXED_SRCS)*PRIO_W +: PRIO_W] & IMPL;
      assign lvl_flat[i*LVL_W +: LVL_W]   = LVL_W'(kept & pm) + LVL_CFG0;
      assign sub_flat[i*PRIO_W +: PRIO_W] = kept & ~pm;
    end
  end
endmodule

// File: rtl/exc_ceiling.sv
module exc_ceiling
  import exc_arb_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int PRIO_BITS = 3
) (
  input  logic [NUM_SRC-1:0]       act,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  input  logic                     gmask,
  input  logic                     fmask,
  input  logic [PRIO_W-1:0]        thr,
  input  logic [2:0]               grp,
  output logic [LVL_W-1:0]         ceiling
);
  localparam logic [PRIO_W-1:0] IMPL = impl_mask(PRIO_BITS);

  logic [PRIO_W-1:0] thr_kept;
  logic [LVL_W-1:0]  thr_lvl;

  assign thr_kept = thr & IMPL;
  assign thr_lvl  = LVL_W'(thr_kept & pre_mask(grp)) + LVL_CFG0;

  always_comb begin
    ceiling = LVL_IDLE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (act[i] && (lvl_flat[i*LVL_W +: LVL_W] < ceiling))
        ceiling = lvl_flat[i*LVL_W +: LVL_W];
    end
    if ((thr_kept != '0) && (thr_lvl < ceiling)) ceiling = thr_lvl;
    if (gmask && (LVL_CFG0 < ceiling))           ceiling = LVL_CFG0;
    if (fmask && (LVL_FAULT < ceiling))          ceiling = LVL_FAULT;
  end
endmodule

// File: rtl/exc_select.sv
module exc_select
  import exc_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*LVL_W-1:0]  lvl_flat,
  input  logic [NUM_SRC*PRIO_W-1:0] sub_flat,
  input  logic [LVL_W-1:0]          ceiling,
  output logic                      win_valid,
  output logic [ID_W-1:0]           win_id
);
  logic [LVL_W-1:0]  best_lvl;
  logic [PRIO_W-1:0] best_sub;

  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    best_lvl  = LVL_IDLE;
    best_sub  = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (lvl_flat[i*LVL_W +: LVL_W] < ceiling)) begin
        if (!win_valid
            || (lvl_flat[i*LVL_W +: LVL_W] < best_lvl)
            || ((lvl_flat[i*LVL_W +: LVL_W] == best_lvl)
                && (sub_flat[i*PRIO_W +: PRIO_W] < best_sub))) begin
          win_valid = 1'b1;
          win_id    = ID_W'(i);
          best_lvl  = lvl_flat[i*LVL_W +: LVL_W];
          best_sub  = sub_flat[i*PRIO_W +: PRIO_W];
        end
      end
    end
  end
endmodule

// File: rtl/exc_prio_arbiter.sv
module exc_prio_arbiter
  import exc_arb_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int PRIO_BITS = 3,
  parameter int ID_W      = $clog2(NUM_SRC)
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [NUM_SRC-1:0]                     src_req,
  input  logic [NUM_SRC-1:0]                     sw_pend_set,
  input  logic [NUM_SRC-1:0]                     sw_pend_clr,
  input  logic [NUM_SRC-FIXED_SRCS-1:0]          src_en,
  input  logic [(NUM_SRC-FIXED_SRCS)*PRIO_W-1:0] src_prio,
  input  logic [2:0]                             prio_group,
  input  logic                                   global_mask,
  input  logic                                   fault_mask_wr,
  input  logic                                   fault_mask_val,
  input  logic [PRIO_W-1:0]                      thresh,
  input  logic                                   ack,
  input  logic                                   ret,
  input  logic [ID_W-1:0]                        ret_id,
  output logic                                   take_req,
  output logic [ID_W-1:0]                        take_id,
  output logic [LVL_W-1:0]                       exec_prio,
  output logic                                   fault_mask
);
  logic [NUM_SRC-1:0]        pend, act, ack_hit, ret_hit, en_full, cand;
  logic [NUM_SRC*LVL_W-1:0]  lvl_flat;
  logic [NUM_SRC*PRIO_W-1:0] sub_flat;
  logic [LVL_W-1:0]          ceiling;
  logic                      win_valid;
  logic [ID_W-1:0]           win_id;

  assign en_full = {src_en, {FIXED_SRCS{1'b1}}};
  assign cand    = pend & ~act & en_full;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_state
    assign ack_hit[i] = ack && take_req && (take_id == ID_W'(i)) && pend[i] && !act[i];
    assign ret_hit[i] = ret && (ret_id == ID_W'(i));
    exc_src_state state_i (
      .clk     (clk),
      .rst     (rst),
      .hw_req  (src_req[i]),
      .sw_set  (sw_pend_set[i]),
      .sw_clr  (sw_pend_clr[i]),
      .ack_hit (ack_hit[i]),
      .ret_hit (ret_hit[i]),
      .pend    (pend[i]),
      .act     (act[i])
    );
  end

  exc_level_calc #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS)) level_i (
    .prio_cfg (src_prio),
    .grp      (prio_group),
    .lvl_flat (lvl_flat),
    .sub_flat (sub_flat)
  );

  exc_ceiling #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS)) ceil_i (
    .act      (act),
    .lvl_flat (lvl_flat),
    .gmask    (global_mask),
    .fmask    (fault_mask),
    .thr      (thresh),
    .grp      (prio_group),
    .ceiling  (ceiling)
  );

  exc_select #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) sel_i (
    .cand      (cand),
    .lvl_flat  (lvl_flat),
    .sub_flat  (sub_flat),
    .ceiling   (ceiling),
    .win_valid (win_valid),
    .win_id    (win_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_mask <= 1'b0;
    end else if (ret && (ret_id != ID_W'(0))) begin
      fault_mask <= 1'b0;
    end else if (fault_mask_wr) begin
      fault_mask <= fault_mask_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_req  <= 1'b0;
      take_id   <= '0;
      exec_prio <= LVL_IDLE;
    end else begin
      take_req  <= win_valid && !(ack && take_req);
      take_id   <= win_id;
      exec_prio <= ceiling;
    end
  end
endmodule

// File: rtl/exc_prio_arbiter_chk.sv
module exc_prio_arbiter_chk #(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = $clog2(NUM_SRC)
) (
  input logic            clk,
  input logic            rst,
  input logic            global_mask,
  input logic            ack,
  input logic            ret,
  input logic [ID_W-1:0] ret_id,
  input logic            take_req,
  input logic [ID_W-1:0] take_id,
  input logic [8:0]      exec_prio,
  input logic            fault_mask
);
  assert_gmask_take_R6: assert property (@(posedge clk) disable iff (rst)
    (take_req && $past(global_mask)) |-> (take_id < ID_W'(2)));

  assert_gmask_level_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(global_mask)) |-> (exec_prio <= 9'd2));

  assert_fmask_block_R7: assert property (@(posedge clk) disable iff (rst)
    (take_req && (take_id == ID_W'(1))) |-> !$past(fault_mask));

  assert_fmask_autoclr_R7: assert property (@(posedge clk) disable iff (rst)
    (ret && (ret_id != ID_W'(0))) |=> !fault_mask);

  assert_ack_drop_R12: assert property (@(posedge clk) disable iff (rst)
    (ack && take_req) |=> !take_req);
endmodule

bind exc_prio_arbiter exc_prio_arbiter_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .global_mask (global_mask),
  .ack         (ack),
  .ret         (ret),
  .ret_id      (ret_id),
  .take_req    (take_req),
  .take_id     (take_id),
  .exec_prio   (exec_prio),
  .fault_mask  (fault_mask)
);

// File: tb/exc_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module exc_prio_arbiter_tb_top;
  localparam int NS = 8;
  localparam int PB = 3;
  localparam int IW = $clog2(NS);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NS-1:0]     src_req = '0, sset = '0, sclr = '0;
  logic [NS-3:0]     en = '1;
  logic [(NS-2)*8-1:0] prio = '0;
  logic [2:0]        grp = '0;
  logic              gmask = 1'b0, fm_wr = 1'b0, fm_val = 1'b0;
  logic [7:0]        thr = '0;
  logic              ack = 1'b0, ret = 1'b0;
  logic [IW-1:0]     ret_id = '0;
  logic              take_req, fault_mask;
  logic [IW-1:0]     take_id;
  logic [8:0]        exec_prio;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  exc_prio_arbiter #(.NUM_SRC(NS), .PRIO_BITS(PB)) dut_i (
    .clk(clk), .rst(rst), .src_req(src_req), .sw_pend_set(sset), .sw_pend_clr(sclr),
    .src_en(en), .src_prio(prio), .prio_group(grp), .global_mask(gmask),
    .fault_mask_wr(fm_wr), .fault_mask_val(fm_val), .thresh(thr), .ack(ack),
    .ret(ret), .ret_id(ret_id), .take_req(take_req), .take_id(take_id),
    .exec_prio(exec_prio), .fault_mask(fault_mask)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int got_id();
    return take_req ? int'(take_id) : -1;
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic pend_src(input int s); sset[s] = 1'b1; tick(); sset = '0; tick(); endtask
  task automatic clr_src(input int s);  sclr[s] = 1'b1; tick(); sclr = '0; tick(); endtask
  task automatic do_ret(input int s);
    ret = 1'b1; ret_id = IW'(s); tick(); ret = 1'b0; tick();
  endtask
  task automatic do_ack(input string req);
    ack = 1'b1; tick(); ack = 1'b0;
    check(!take_req, req, int'(take_req), 0);
    tick();
  endtask
  task automatic set_prio(input int s, input int v); prio[(s-2)*8 +: 8] = 8'(v); endtask

  // expected preemption part / sub-priority from the requirement arithmetic
  function automatic int e_pre(input int v, input int g);
    return (v & 8'hE0) & ((255 << (g + 1)) & 255);
  endfunction
  function automatic int e_sub(input int v, input int g);
    return (v & 8'hE0) & ~((255 << (g + 1)) & 255) & 255;
  endfunction

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check(!take_req, "R1", int'(take_req), 0);
    check(exec_prio == 9'd511, "R1", int'(exec_prio), 511);
    check(!fault_mask, "R1", int'(fault_mask), 0);

    // R12 ack with nothing presented is ignored
    do_ack("R12");
    check(exec_prio == 9'd511, "R12", int'(exec_prio), 511);

    // R10 / R9 sweep: grouping x pair of priorities with junk low bits
    for (int g = 0; g < 8; g++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          int va, vb, exp;
          va = (a << 5) | ((a * 7 + g) & 31);
          vb = (b << 5) | ((b * 3 + 5) & 31);
          grp = 3'(g);
          set_prio(2, va);
          set_prio(3, vb);
          sset[2] = 1'b1; sset[3] = 1'b1; tick(); sset = '0; tick();
          if (e_pre(va, g) != e_pre(vb, g)) exp = (e_pre(va, g) < e_pre(vb, g)) ? 2 : 3;
          else exp = (e_sub(vb, g) < e_sub(va, g)) ? 3 : 2;
          check(take_req && (take_id == IW'(exp)), "R10", got_id(), exp);
          sclr[2] = 1'b1; sclr[3] = 1'b1; tick(); sclr = '0; tick();
        end
      end
    end
    check(!take_req, "R11", int'(take_req), 0);

    // R9: only the upper bits count -> 0x1F ties with 0x00, lower number wins
    grp = 3'd2;
    set_prio(4, 8'h1F); set_prio(5, 8'h00);
    sset[4] = 1'b1; sset[5] = 1'b1; tick(); sset = '0; tick();
    check(take_req && take_id == 3'd4, "R9", got_id(), 4);
    do_ack("R12");
    check(exec_prio == 9'd2, "R9", int'(exec_prio), 2);
    check(!take_req, "R5", got_id(), -1);
    do_ret(4);
    check(take_req && take_id == 3'd5, "R9", got_id(), 5);
    do_ack("R12"); do_ret(5);

    // R5 / R4 / R2 nesting, grp 2 (preemption = kept bits)
    set_prio(2, 8'h80); set_prio(3, 8'h40); set_prio(4, 8'h80);
    pend_src(2);
    check(take_req && take_id == 3'd2, "R5", got_id(), 2);
    do_ack("R12");
    check(exec_prio == 9'd130, "R4", int'(exec_prio), 130);
    pend_src(4);
    check(!take_req, "R5", got_id(), -1);
    pend_src(3);
    check(take_req && take_id == 3'd3, "R5", got_id(), 3);
    do_ack("R12");
    check(exec_prio == 9'd66, "R4", int'(exec_prio), 66);
    do_ret(3);
    check(exec_prio == 9'd130, "R4", int'(exec_prio), 130);
    check(!take_req, "R5", got_id(), -1);
    src_req[2] = 1'b1; tick(); src_req = '0; tick();   // R2 request while in service
    check(!take_req, "R2", got_id(), -1);
    do_ret(2);
    check(take_req && take_id == 3'd2, "R2", got_id(), 2);
    do_ack("R12"); do_ret(2);
    check(take_req && take_id == 3'd4, "R2", got_id(), 4);
    do_ack("R12"); do_ret(4);
    check(exec_prio == 9'd511 && !take_req, "R4", int'(exec_prio), 511);

    // R11: clear wins over set, hardware request wins over clear
    sset[6] = 1'b1; sclr[6] = 1'b1; tick(); sset = '0; sclr = '0; tick();
    check(!take_req, "R11", got_id(), -1);
    src_req[6] = 1'b1; sclr[6] = 1'b1; tick(); src_req = '0; sclr = '0; tick();
    check(take_req && take_id == 3'd6, "R11", got_id(), 6);
    clr_src(6);
    check(!take_req, "R11", got_id(), -1);

    // R6 global mask
    grp = 3'd0;
    set_prio(5, 8'h00);
    gmask = 1'b1; tick(); tick();
    check(exec_prio == 9'd2, "R6", int'(exec_prio), 2);
    pend_src(5);
    check(!take_req, "R6", got_id(), -1);
    pend_src(0);
    check(take_req && take_id == 3'd0, "R6", got_id(), 0);
    do_ack("R12");
    check(exec_prio == 9'd0, "R4", int'(exec_prio), 0);
    do_ret(0);
    gmask = 1'b0; tick(); tick();
    check(take_req && take_id == 3'd5, "R6", got_id(), 5);
    do_ack("R12");

    // R7 fault mask with source 5 in service
    fm_wr = 1'b1; fm_val = 1'b1; tick(); fm_wr = 1'b0; fm_val = 1'b0; tick();
    check(fault_mask && exec_prio == 9'd1, "R7", int'(exec_prio), 1);
    pend_src(1);
    check(!take_req, "R7", got_id(), -1);
    pend_src(0);
    check(take_req && take_id == 3'd0, "R7", got_id(), 0);
    do_ack("R12"); do_ret(0);
    check(fault_mask, "R7", int'(fault_mask), 1);
    do_ret(5);
    check(!fault_mask, "R7", int'(fault_mask), 0);
    check(take_req && take_id == 3'd1, "R7", got_id(), 1);
    do_ack("R12");
    check(exec_prio == 9'd1, "R4", int'(exec_prio), 1);
    do_ret(1);

    // R8 threshold sweep, grp 0, with junk bits below the kept ones
    for (int t = 0; t < 8; t++) begin
      for (int s = 0; s < 8; s++) begin
        bit exp_take;
        thr = 8'((t << 5) | 5'h0B);
        set_prio(6, (s << 5) | 3);
        tick();
        pend_src(6);
        exp_take = (t == 0) || (s < t);
        check(take_req == exp_take, "R8", int'(take_req), int'(exp_take));
        check(exec_prio == ((t == 0) ? 9'd511 : 9'(2 + (t << 5))), "R8",
              int'(exec_prio), (t == 0) ? 511 : 2 + (t << 5));
        clr_src(6);
      end
    end
    thr = '0;

    // R3 enable gating; request kept while disabled
    en[7-2] = 1'b0;
    set_prio(7, 8'h20);
    pend_src(7);
    check(!take_req, "R3", got_id(), -1);
    en[7-2] = 1'b1; tick(); tick();
    check(take_req && take_id == 3'd7, "R3", got_id(), 7);
    en[7-2] = 1'b0; tick(); tick();
    check(!take_req, "R3", got_id(), -1);
    clr_src(7);
    en[7-2] = 1'b1; tick(); tick();
    check(!take_req, "R3", got_id(), -1);
    en = '0;
    pend_src(1);
    check(take_req && take_id == 3'd1, "R3", got_id(), 1);
    do_ack("R12"); do_ret(1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule